// File: doc/BRIEF.md
# Ethernet PHY Management Register Slave

This block is the management-side slave of an Ethernet PHY. Its clock is the serial management clock. It samples the bidirectional data line on each rising clock edge and decodes read and write frames. A frame is acted on only when its PHY address equals the strapped address on `phy_addr_i`. On a read it drives the line through an output enable. The block answers a 32-entry space of 16-bit registers. The space holds control, status, identifier, advertisement, expansion, next-page transmit, link-partner next-page, reserved, vendor control and vendor test registers. Each register has its own reset value and access rule.

A frame starts with the delimiter 01. Then come a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround and 16 data bits, all MSB first. A preamble of ones may come before the delimiter or may be left out. The idle state treats ones as filler and waits for the first zero. The decoded control values leave the block as configuration outputs. The link-partner next-page register is loaded only by a local strobe.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A frame is accepted both after 32 ones of preamble and with no preamble, including back to back. The status register (address 1) reads 7849h, and its bit 6 = 1 advertises preamble-free frames.
- R2: On a matching read, `mdio_oe_o` stays low during the first turnaround bit. During the second it is high with `mdio_o` = 0. It then stays high for the 16 data bits, MSB first, and goes low after the last one.
- R3: A frame whose PHY address differs from `phy_addr_i` never raises `mdio_oe_o`, and its writes change nothing.
- R4: A start of 00, or an opcode of 00 or 11, returns the slave to idle with no drive and no write. The next valid frame is handled normally.
- R5: Address 2 reads 1A2Bh. Address 3 reads B030h: OUI bits 101100 in [15:10], model 000011 in [9:4], revision 0000 in [3:0]. Writes to both are ignored.
- R6: Address 6 reads 0004h (bit 2, next page able, set). Address 7 is read/write with reset value 2001h and appears on `np_tx_o`.
- R7: Address 8 resets to 0000h. It is loaded from `lp_np_data_i` on a clock edge where `lp_np_load_i` is high. Management writes to it are ignored.
- R8: Addresses 9 to 15 read FFFFh, and writes to them are ignored.
- R9: Address 18 bit 15 (reset 0) drives `rjab_en_o` and address 19 bit 1 (reset 1) drives `apd10_en_o`. All other bits of these two registers read 0.
- R10: Addresses 20 to 31 are plain read/write registers that reset to 0000h.
- R11: Writing address 0 with bit 15 = 1 returns every register to its reset value, and bit 15 always reads 0. Otherwise bits 14:0 of address 0 are read/write with reset 3100h and appear on `ctrl_o`.
- R12: When a soft-reset write and a link-partner load strobe land on the same edge, the soft reset wins and address 8 reads 0000h.
- R13: While and after `rst_n` is low, `mdio_oe_o` is low and every configuration output holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_i | input | 5 | Strapped PHY address of this slave |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe_o | output | 1 | Output enable for the data line |
| lp_np_load_i | input | 1 | Load strobe for the link-partner next-page register |
| lp_np_data_i | input | 16 | Value loaded into the link-partner next-page register |
| ctrl_o | output | 16 | Current control register value |
| np_tx_o | output | 16 | Current next-page transmit register value |
| rjab_en_o | output | 1 | Remote jabber enable |
| apd10_en_o | output | 1 | Automatic 10M power-down enable |

## Verification
The link-partner load strobe and a management write to the control register can land on the same clock edge. When that write sets the soft-reset bit, the two functions collide on the same register. The bench raises the strobe with a new value during the final data bit of a soft-reset write. Its model applies the load first and the reset second, so address 8 is expected to read 0000h on a later read. A separate edge where only the strobe is high shows that the load works on its own.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int MGMT_DW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_OPC,
    ST_HDR,
    ST_TURN1,
    ST_TURN2,
    ST_DATA
  } mdio_st_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  localparam int RA_CTRL   = 0;
  localparam int RA_STAT   = 1;
  localparam int RA_ID1    = 2;
  localparam int RA_ID2    = 3;
  localparam int RA_ADV    = 4;
  localparam int RA_LPA    = 5;
  localparam int RA_EXP    = 6;
  localparam int RA_NPTX   = 7;
  localparam int RA_NPRX   = 8;
  localparam int RA_RSV_LO = 9;
  localparam int RA_RSV_HI = 15;
  localparam int RA_VCTL   = 18;
  localparam int RA_VPWR   = 19;
  localparam int RA_SCR_LO = 20;

  localparam logic [MGMT_DW-1:0] CTRL_DEF = 16'h3100;
  localparam logic [MGMT_DW-1:0] STAT_VAL = 16'h7849;
  localparam logic [MGMT_DW-1:0] ADV_DEF  = 16'h01E1;
  localparam logic [MGMT_DW-1:0] EXP_VAL  = 16'h0004;
  localparam logic [MGMT_DW-1:0] NPTX_DEF = 16'h2001;
  localparam logic [MGMT_DW-1:0] RSV_VAL  = 16'hFFFF;

  localparam logic [5:0] MODEL_NUM = 6'b000011;
  localparam logic [3:0] REV_NUM   = 4'b0000;

  localparam int RJAB_BIT = 15;
  localparam int APD_BIT  = 1;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_mgmt_pkg::*;
#(
  parameter int PAW = 5,
  parameter int RAW = 5,
  parameter int DW  = MGMT_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PAW-1:0] phy_addr_i,
  input  logic           mdio_i,
  output logic           mdio_o,
  output logic           mdio_oe_o,
  output logic [RAW-1:0] rd_addr_o,
  input  logic [DW-1:0]  rd_data_i,
  output logic           wr_en_o,
  output logic [RAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o
);

  localparam int HW = PAW + RAW;
  localparam int CW = $clog2(HW + DW);
  localparam logic [CW-1:0] HDR_LAST  = CW'(HW - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);

  mdio_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [HW-1:0]   hdr_q, hdr_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            opb_q, opb_d;
  logic            is_rd_q, is_rd_d;
  logic            is_wr_q, is_wr_d;
  logic            hit_q, hit_d;
  logic [1:0]      opc;

  assign opc = {opb_q, mdio_i};

  // next-state process
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    sh_d    = sh_q;
    opb_d   = opb_q;
    is_rd_d = is_rd_q;
    is_wr_d = is_wr_q;
    hit_d   = hit_q;
    wr_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!mdio_i) st_d = ST_SOF;
      end
      ST_SOF: begin
        cnt_d = '0;
        st_d  = mdio_i ? ST_OPC : ST_IDLE;
      end
      ST_OPC: begin
        if (cnt_q == '0) begin
          opb_d = mdio_i;
          cnt_d = CW'(1);
        end else begin
          is_rd_d = (opc == OPC_RD);
          is_wr_d = (opc == OPC_WR);
          cnt_d   = '0;
          st_d    = ((opc == OPC_RD) || (opc == OPC_WR)) ? ST_HDR : ST_IDLE;
        end
      end
      ST_HDR: begin
        hdr_d = {hdr_q[HW-2:0], mdio_i};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == HDR_LAST) begin
          cnt_d = '0;
          st_d  = ST_TURN1;
        end
      end
      ST_TURN1: begin
        hit_d = (hdr_q[HW-1 -: PAW] == phy_addr_i);
        sh_d  = rd_data_i;
        st_d  = ST_TURN2;
      end
      ST_TURN2: begin
        cnt_d = '0;
        st_d  = ST_DATA;
      end
      ST_DATA: begin
        sh_d  = {sh_q[DW-2:0], mdio_i};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == DATA_LAST) begin
          cnt_d   = '0;
          st_d    = ST_IDLE;
          wr_en_o = is_wr_q && hit_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      opb_q   <= 1'b0;
      is_rd_q <= 1'b0;
      is_wr_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      sh_q    <= sh_d;
      opb_q   <= opb_d;
      is_rd_q <= is_rd_d;
      is_wr_q <= is_wr_d;
      hit_q   <= hit_d;
    end
  end

  assign rd_addr_o = hdr_q[RAW-1:0];
  assign wr_addr_o = hdr_q[RAW-1:0];
  assign wr_data_o = {sh_q[DW-2:0], mdio_i};
  assign mdio_oe_o = hit_q && is_rd_q && ((st_q == ST_TURN2) || (st_q == ST_DATA));
  assign mdio_o    = (st_q == ST_DATA) && sh_q[DW-1];

  // R2: the first driven bit is the turnaround zero
  a_r2_turn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe_o) |-> !mdio_o);

  // R2: drive starts only right after the first turnaround bit
  a_r2_after_turn1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe_o) |-> ($past(st_q) == ST_TURN1));

  // R3: a write leaves only for the strapped address
  a_r3_wr_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (hdr_q[HW-1 -: PAW] == phy_addr_i));

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int              RAW     = 5,
  parameter logic [15:0]     ID_HI   = 16'h1A2B,
  parameter logic [5:0]      ID_OUI6 = 6'b101100,
  parameter int              SCR_LO  = RA_SCR_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RAW-1:0]     rd_addr_i,
  output logic [MGMT_DW-1:0] rd_data_o,
  input  logic               wr_en_i,
  input  logic [RAW-1:0]     wr_addr_i,
  input  logic [MGMT_DW-1:0] wr_data_i,
  input  logic               lp_load_i,
  input  logic [MGMT_DW-1:0] lp_data_i,
  output logic [MGMT_DW-1:0] ctrl_o,
  output logic [MGMT_DW-1:0] np_tx_o,
  output logic               rjab_en_o,
  output logic               apd_en_o
);

  localparam int DW    = MGMT_DW;
  localparam int NREG  = 1 << RAW;
  localparam int SCR_N = NREG - SCR_LO;

  localparam logic [RAW-1:0] A_CTRL   = RAW'(RA_CTRL);
  localparam logic [RAW-1:0] A_STAT   = RAW'(RA_STAT);
  localparam logic [RAW-1:0] A_ID1    = RAW'(RA_ID1);
  localparam logic [RAW-1:0] A_ID2    = RAW'(RA_ID2);
  localparam logic [RAW-1:0] A_ADV    = RAW'(RA_ADV);
  localparam logic [RAW-1:0] A_EXP    = RAW'(RA_EXP);
  localparam logic [RAW-1:0] A_NPTX   = RAW'(RA_NPTX);
  localparam logic [RAW-1:0] A_NPRX   = RAW'(RA_NPRX);
  localparam logic [RAW-1:0] A_RSV_LO = RAW'(RA_RSV_LO);
  localparam logic [RAW-1:0] A_RSV_HI = RAW'(RA_RSV_HI);
  localparam logic [RAW-1:0] A_VCTL   = RAW'(RA_VCTL);
  localparam logic [RAW-1:0] A_VPWR   = RAW'(RA_VPWR);

  logic [DW-2:0] ctrl_q, ctrl_d;
  logic [DW-1:0] adv_q, adv_d;
  logic [DW-1:0] nptx_q, nptx_d;
  logic [DW-1:0] lp_q, lp_d;
  logic          rjab_q, rjab_d;
  logic          apd_q, apd_d;
  logic          ctrl_en, adv_en, nptx_en, lp_en, rjab_en, apd_en;
  logic          srst;
  logic [DW-1:0] scr_q [SCR_N];

  assign srst = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[DW-1];

  // next-state process with explicit clock enables
  always_comb begin
    ctrl_en = srst || (wr_en_i && (wr_addr_i == A_CTRL));
    ctrl_d  = srst ? CTRL_DEF[DW-2:0] : wr_data_i[DW-2:0];
    adv_en  = srst || (wr_en_i && (wr_addr_i == A_ADV));
    adv_d   = srst ? ADV_DEF : wr_data_i;
    nptx_en = srst || (wr_en_i && (wr_addr_i == A_NPTX));
    nptx_d  = srst ? NPTX_DEF : wr_data_i;
    lp_en   = srst || lp_load_i;
    lp_d    = srst ? '0 : lp_data_i;
    rjab_en = srst || (wr_en_i && (wr_addr_i == A_VCTL));
    rjab_d  = srst ? 1'b0 : wr_data_i[RJAB_BIT];
    apd_en  = srst || (wr_en_i && (wr_addr_i == A_VPWR));
    apd_d   = srst ? 1'b1 : wr_data_i[APD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF[DW-2:0];
      adv_q  <= ADV_DEF;
      nptx_q <= NPTX_DEF;
      lp_q   <= '0;
      rjab_q <= 1'b0;
      apd_q  <= 1'b1;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (adv_en)  adv_q  <= adv_d;
      if (nptx_en) nptx_q <= nptx_d;
      if (lp_en)   lp_q   <= lp_d;
      if (rjab_en) rjab_q <= rjab_d;
      if (apd_en)  apd_q  <= apd_d;
    end
  end

  // vendor test space: one register per address
  for (genvar gi = 0; gi < SCR_N; gi++) begin : g_scr
    logic          s_en;
    logic [DW-1:0] s_d;
    always_comb begin
      s_en = srst || (wr_en_i && (wr_addr_i == RAW'(SCR_LO + gi)));
      s_d  = srst ? '0 : wr_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    scr_q[gi] <= '0;
      else if (s_en) scr_q[gi] <= s_d;
    end
  end

  // read multiplexer
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL)      rd_data_o = {1'b0, ctrl_q};
    else if (rd_addr_i == A_STAT) rd_data_o = STAT_VAL;
    else if (rd_addr_i == A_ID1)  rd_data_o = ID_HI;
    else if (rd_addr_i == A_ID2)  rd_data_o = {ID_OUI6, MODEL_NUM, REV_NUM};
    else if (rd_addr_i == A_ADV)  rd_data_o = adv_q;
    else if (rd_addr_i == A_EXP)  rd_data_o = EXP_VAL;
    else if (rd_addr_i == A_NPTX) rd_data_o = nptx_q;
    else if (rd_addr_i == A_NPRX) rd_data_o = lp_q;
    else if ((rd_addr_i >= A_RSV_LO) && (rd_addr_i <= A_RSV_HI)) rd_data_o = RSV_VAL;
    else if (rd_addr_i == A_VCTL) rd_data_o = {rjab_q, {(DW-1){1'b0}}};
    else if (rd_addr_i == A_VPWR) rd_data_o = {{(DW-2){1'b0}}, apd_q, 1'b0};
    else begin
      for (int i = 0; i < SCR_N; i++) begin
        if (rd_addr_i == RAW'(SCR_LO + i)) rd_data_o = scr_q[i];
      end
    end
  end

  assign ctrl_o    = {1'b0, ctrl_q};
  assign np_tx_o   = nptx_q;
  assign rjab_en_o = rjab_q;
  assign apd_en_o  = apd_q;

  // R11: a soft-reset write leaves every output at its reset value
  a_r11_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ((np_tx_o == NPTX_DEF) && (ctrl_o == CTRL_DEF) && !rjab_en_o && apd_en_o));

  // R7: without a strobe or soft reset the partner register holds
  a_r7_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_load_i && !srst) |=> $stable(lp_q));

  // R12: soft reset beats a coincident load
  a_r12_srst_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_load_i && srst) |=> (lp_q == '0));

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int          PHY_AW  = 5,
  parameter int          REG_AW  = 5,
  parameter logic [15:0] ID_HI   = 16'h1A2B,
  parameter logic [5:0]  ID_OUI6 = 6'b101100
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [PHY_AW-1:0]  phy_addr_i,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic               lp_np_load_i,
  input  logic [MGMT_DW-1:0] lp_np_data_i,
  output logic [MGMT_DW-1:0] ctrl_o,
  output logic [MGMT_DW-1:0] np_tx_o,
  output logic               rjab_en_o,
  output logic               apd10_en_o
);

  logic                rs_meta_q, rs_sync_q;
  logic [REG_AW-1:0]   rd_addr, wr_addr;
  logic [MGMT_DW-1:0]  rd_data, wr_data;
  logic                wr_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  mdio_frame_engine #(
    .PAW (PHY_AW),
    .RAW (REG_AW),
    .DW  (MGMT_DW)
  ) u_frame (
    .clk        (mdc),
    .rst_n      (rs_sync_q),
    .phy_addr_i (phy_addr_i),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  phy_mgmt_regfile #(
    .RAW     (REG_AW),
    .ID_HI   (ID_HI),
    .ID_OUI6 (ID_OUI6),
    .SCR_LO  (RA_SCR_LO)
  ) u_regs (
    .clk       (mdc),
    .rst_n     (rs_sync_q),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .lp_load_i (lp_np_load_i),
    .lp_data_i (lp_np_data_i),
    .ctrl_o    (ctrl_o),
    .np_tx_o   (np_tx_o),
    .rjab_en_o (rjab_en_o),
    .apd_en_o  (apd10_en_o)
  );

endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

  localparam logic [4:0] MY_PHY = 5'h0B;
  localparam logic [4:0] OTHER  = 5'h03;

  logic        mdc = 1'b0;
  logic        rst_n, mdio_i, lp_ld;
  logic [15:0] lp_dat;
  logic        mdio_o, mdio_oe_o, rjab_en_o, apd10_en_o;
  logic [15:0] ctrl_o, np_tx_o;

  always #5 mdc = ~mdc;

  phy_mgmt_regs uut (
    .mdc          (mdc),
    .rst_n        (rst_n),
    .phy_addr_i   (MY_PHY),
    .mdio_i       (mdio_i),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe_o),
    .lp_np_load_i (lp_ld),
    .lp_np_data_i (lp_dat),
    .ctrl_o       (ctrl_o),
    .np_tx_o      (np_tx_o),
    .rjab_en_o    (rjab_en_o),
    .apd10_en_o   (apd10_en_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R13";
  logic  exp_oe, exp_out, chk_en;

  // behavioural register model
  logic [14:0] m_ctrl;
  logic [15:0] m_adv, m_nptx, m_lp;
  logic        m_rj, m_apd;
  logic [15:0] m_scr [12];

  task automatic m_defaults();
    m_ctrl = 15'h3100; m_adv = 16'h01E1; m_nptx = 16'h2001; m_lp = 16'h0000;
    m_rj = 1'b0; m_apd = 1'b1;
    for (int i = 0; i < 12; i++) m_scr[i] = 16'h0000;
  endtask

  function automatic logic [15:0] m_read(int a);
    if (a == 0) return {1'b0, m_ctrl};
    if (a == 1) return 16'h7849;
    if (a == 2) return 16'h1A2B;
    if (a == 3) return 16'hB030;
    if (a == 4) return m_adv;
    if (a == 6) return 16'h0004;
    if (a == 7) return m_nptx;
    if (a == 8) return m_lp;
    if (a >= 9 && a <= 15) return 16'hFFFF;
    if (a == 18) return {m_rj, 15'h0};
    if (a == 19) return {14'h0, m_apd, 1'b0};
    if (a >= 20) return m_scr[a-20];
    return 16'h0000;
  endfunction

  task automatic m_write(int a, logic [15:0] d);
    if (a == 0) begin
      if (d[15]) m_defaults(); else m_ctrl = d[14:0];
    end
    else if (a == 4) m_adv = d;
    else if (a == 7) m_nptx = d;
    else if (a == 18) m_rj = d[15];
    else if (a == 19) m_apd = d[1];
    else if (a >= 20) m_scr[a-20] = d;
  endtask

  task automatic chk(bit ok, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  // compare against the model every clock, away from the sampling edge
  always @(negedge mdc) begin
    if (chk_en) begin
      chk(mdio_oe_o === exp_oe, "mdio_oe", {15'h0, mdio_oe_o}, {15'h0, exp_oe});
      if (exp_oe) chk(mdio_o === exp_out, "mdio_out", {15'h0, mdio_o}, {15'h0, exp_out});
      chk(ctrl_o === {1'b0, m_ctrl}, "ctrl_o", ctrl_o, {1'b0, m_ctrl});
      chk(np_tx_o === m_nptx, "np_tx_o", np_tx_o, m_nptx);
      chk(rjab_en_o === m_rj, "rjab_en_o", {15'h0, rjab_en_o}, {15'h0, m_rj});
      chk(apd10_en_o === m_apd, "apd10_en_o", {15'h0, apd10_en_o}, {15'h0, m_apd});
    end
  end

  task automatic send_bit(logic v, logic eoe, logic eout);
    mdio_i = v; exp_oe = eoe; exp_out = eout;
    @(posedge mdc); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send_raw(logic [7:0] bits, int n);
    for (int i = 0; i < n; i++) send_bit(bits[7-i], 1'b0, 1'b0);
  endtask

  task automatic frame(bit pre, logic [1:0] op, logic [4:0] pa, logic [4:0] ra,
                       logic [15:0] d, bit lp_also = 1'b0, logic [15:0] lpd = 16'h0);
    logic [31:0] fb;
    logic [15:0] rv;
    bit          rd_hit;
    if (pre) idle(32);
    rv     = m_read(int'(ra));
    rd_hit = (op == 2'b10) && (pa == MY_PHY);
    fb     = {2'b01, op, pa, ra, (op == 2'b01) ? 2'b10 : 2'b11, (op == 2'b01) ? d : 16'hFFFF};
    for (int k = 0; k < 32; k++) begin
      if (k == 31 && lp_also) begin lp_ld = 1'b1; lp_dat = lpd; end
      send_bit(fb[31-k], rd_hit && (k >= 15), (k >= 16) ? rv[31-k] : 1'b0);
    end
    lp_ld = 1'b0;
    if (lp_also) m_lp = lpd;
    if (op == 2'b01 && pa == MY_PHY) m_write(int'(ra), d);
  endtask

  task automatic rd(logic [4:0] ra); frame(1'b0, 2'b10, MY_PHY, ra, 16'h0); endtask
  task automatic wr(logic [4:0] ra, logic [15:0] d); frame(1'b0, 2'b01, MY_PHY, ra, d); endtask

  initial begin
    rst_n = 1'b1; mdio_i = 1'b1; lp_ld = 1'b0; lp_dat = 16'h0;
    exp_oe = 1'b0; exp_out = 1'b0; chk_en = 1'b0;
    m_defaults();
    #1 rst_n = 1'b0;
    #1 chk_en = 1'b1;
    // R13: reset state
    repeat (3) @(posedge mdc);
    #1 rst_n = 1'b1;
    idle(4);

    cur_req = "R1";
    frame(1'b1, 2'b10, MY_PHY, 5'd1, 16'h0);
    rd(5'd1);
    rd(5'd1);

    cur_req = "R2";
    wr(5'd4, 16'hA5C3);
    rd(5'd4);
    frame(1'b1, 2'b10, MY_PHY, 5'd7, 16'h0);

    cur_req = "R3";
    frame(1'b0, 2'b01, OTHER, 5'd7, 16'h1111);
    frame(1'b0, 2'b10, OTHER, 5'd7, 16'h0);
    frame(1'b0, 2'b01, OTHER, 5'd18, 16'hFFFF);
    rd(5'd7);

    cur_req = "R4";
    idle(2); send_raw(8'b0011_0000, 2); idle(3);
    send_raw(8'b0111_0000, 4); idle(3);
    send_raw(8'b0100_0000, 4); idle(3);
    wr(5'd20, 16'h00F0);
    rd(5'd20);

    cur_req = "R5";
    rd(5'd2);
    wr(5'd3, 16'hFFFF);
    rd(5'd3);
    wr(5'd2, 16'h0000);
    rd(5'd2);

    cur_req = "R6";
    rd(5'd6);
    rd(5'd7);
    wr(5'd7, 16'hABCD);
    rd(5'd7);

    cur_req = "R7";
    rd(5'd8);
    lp_ld = 1'b1; lp_dat = 16'h5A5A;
    idle(1);
    lp_ld = 1'b0; m_lp = 16'h5A5A;
    rd(5'd8);
    wr(5'd8, 16'h0000);
    rd(5'd8);

    cur_req = "R8";
    for (int a = 9; a <= 15; a++) begin
      wr(5'(a), 16'h0000);
      rd(5'(a));
    end

    cur_req = "R9";
    rd(5'd18); rd(5'd19);
    wr(5'd18, 16'hFFFF); rd(5'd18);
    wr(5'd19, 16'h0000); rd(5'd19);
    wr(5'd19, 16'hFFFF); rd(5'd19);

    cur_req = "R10";
    for (int a = 20; a <= 31; a++) rd(5'(a));
    for (int a = 20; a <= 31; a++) wr(5'(a), 16'h3C00 + 16'(a * 37));
    for (int a = 20; a <= 31; a++) rd(5'(a));

    cur_req = "R11";
    wr(5'd0, 16'h1234);
    rd(5'd0);
    wr(5'd0, 16'h8000);
    rd(5'd0); rd(5'd7); rd(5'd18); rd(5'd19); rd(5'd25); rd(5'd8); rd(5'd4);

    cur_req = "R12";
    lp_ld = 1'b1; lp_dat = 16'h1234;
    idle(1);
    lp_ld = 1'b0; m_lp = 16'h1234;
    rd(5'd8);
    wr(5'd7, 16'h7777);
    frame(1'b0, 2'b01, MY_PHY, 5'd0, 16'h8000, 1'b1, 16'h4321);
    rd(5'd8);
    rd(5'd7);
    idle(4);

    chk_en = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mdc);
    n_bad++;
    $display("FAIL %s watchdog act=running exp=finished", cur_req);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule